// File: doc/BRIEF.md
# Interleaved Four-Bank Block Transfer Controller

This controller moves whole cache blocks between a cache and a word-wide memory split into four interleaved banks, over a bus one word wide. The word at block offset i is held in bank i at the row named by the block address. Consecutive words of a block therefore sit in different banks, and all four banks can work on one block at the same time.

A read request costs one address cycle. After that the four banks run their fixed-latency reads in parallel, and the four words come back over the bus one per cycle in ascending offset order. A four-word refill with a 15-cycle bank latency takes 1 + 15 + 4 = 20 cycles, not four full sequential accesses. A write request also spends one address cycle. It then collects four words from the bus in offset order and launches all four bank writes in the same cycle, which suits a write-through cache.

Both data directions use valid/ready handshakes, and a word moves on a rising edge where both are high. The request port accepts only while the controller is idle, because one request at a time is in flight. On the read stream, once `rd_valid` rises it stays high with `rd_data` unchanged until the consumer takes the word. Each cycle the consumer holds `rd_ready` low adds one cycle to the transfer. On the write stream, `wr_ready` stays high for the whole collection phase. Each cycle the producer holds `wr_valid` low adds one cycle. A debug counter shows how many cycles the current or most recent request has taken.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and `rd_valid`, `wr_ready` and `done` are 0, and `cyc_count` is 0.
- R2: `req_ready` is high exactly when the controller is idle. A request is taken only on an edge where `req_valid` and `req_ready` are both high. A `req_valid` held high during a transfer starts nothing, and its address and direction have no effect on any bank.
- R3: For a read with `rd_ready` held high, `rd_valid` first rises in cycle 17 after the accepting edge (1 address cycle + 15 latency cycles) and stays high for four consecutive cycles.
- R4: Read words appear in ascending block offset 0,1,2,3. The word at offset i equals the word last written at offset i of the same block address.
- R5: While `rd_valid` is high and `rd_ready` is low, the next cycle still has `rd_valid` high and the same `rd_data`.
- R6: After the address cycle of a write, `wr_ready` is high until four words have been taken in offset order 0..3. The four bank writes then finish together after 15 more cycles, so a write with `wr_valid` held high takes 20 cycles.
- R7: `done` is a single-cycle pulse in the cycle after a request's last cycle, and `req_ready` is high in that cycle.
- R8: A write changes only the four words of its own block address. Every other block reads back unchanged.
- R9: `cyc_count` is cleared by the accepting edge and rises by 1 on every edge while the controller is busy. In idle it holds its value, so in the `done` cycle it equals 20 plus the number of stalled handshake cycles.
- R10: `rd_valid` is never high during a write, and `wr_ready` is never high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_addr | input | ROW_W (4) | Block address (bank row) |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Controller collecting write words |
| wr_data | input | WORD_W (32) | Write word, offsets in ascending order |
| rd_valid | output | 1 | Read word present |
| rd_ready | input | 1 | Consumer takes the read word |
| rd_data | output | WORD_W (32) | Read word, offsets in ascending order |
| done | output | 1 | One-cycle pulse after a request finishes |
| cyc_count | output | CNT_W (16) | Cycles taken by the current or last request |

## Verification
The accepting edge is counted as cycle 0, and outputs are sampled at the falling edge of each following cycle. With no stalls, the first read word is due in cycle 17, the last in cycle 20, and `done` with a count of 20 in cycle 21. The bench counts every cycle in which a handshake was held off, by its own `rd_ready` or `wr_valid` choice, and moves the expected word cycles, `done` cycle and count by exactly that number. Every block is written and read back in full, with and without stalls. One block is then rewritten and all others are checked unchanged, and a held-high request during a busy read must leave the memory untouched.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_GATHER,
    S_ACCESS,
    S_STREAM
  } seq_state_e;
endpackage

// File: rtl/ilv_bank.sv
// One memory bank: fixed access latency, one access in flight.
module ilv_bank #(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 4,
  parameter int LAT    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              fin_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CW    = (LAT > 1) ? $clog2(LAT) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              busy_q;
  logic              we_q;
  logic [ROW_W-1:0]  row_q;
  logic [WORD_W-1:0] wdata_q;
  logic [CW-1:0]     cnt_q;
  logic              last_cyc;

  assign last_cyc = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      row_q   <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      we_q    <= we_i;
      row_q   <= row_i;
      wdata_q <= wdata_i;
      cnt_q   <= CW'(LAT - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // array commit at the end of the write latency
  always_ff @(posedge clk) begin
    if (last_cyc && we_q) mem[row_q] <= wdata_q;
  end

  assign fin_o   = last_cyc;
  assign rdata_o = mem[row_q];
endmodule

// File: rtl/ilv_cyc_count.sv
// Per-request cycle counter: cleared on accept, counts busy cycles, holds in idle.
module ilv_cyc_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             busy_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (busy_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/ilv_seq.sv
// Request sequencer: address cycle, parallel bank launch, word streaming.
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 4,
  parameter int NBANK  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ROW_W-1:0]              req_addr,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [WORD_W-1:0]             wr_data,
  output logic                          rd_valid,
  input  logic                          rd_ready,
  output logic [WORD_W-1:0]             rd_data,
  output logic                          done,
  output logic                          bank_start,
  output logic                          bank_we,
  output logic [ROW_W-1:0]              bank_row,
  output logic [NBANK-1:0][WORD_W-1:0]  bank_wdata,
  input  logic [NBANK-1:0]              bank_fin,
  input  logic [NBANK-1:0][WORD_W-1:0]  bank_rdata
);
  localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBANK - 1);

  seq_state_e                 state_q, state_d;
  logic [IDX_W-1:0]           idx_q;
  logic                       write_q;
  logic [ROW_W-1:0]           row_q;
  logic [NBANK-1:0][WORD_W-1:0] buf_q;
  logic                       done_q;

  logic all_fin, at_last, accept, wr_hs, rd_hs, fill, finish;

  assign all_fin = &bank_fin;
  assign at_last = (idx_q == LAST_IDX);
  assign accept  = req_valid && (state_q == S_IDLE);
  assign wr_hs   = (state_q == S_GATHER) && wr_valid;
  assign rd_hs   = (state_q == S_STREAM) && rd_ready;
  assign fill    = (state_q == S_ACCESS) && all_fin && !write_q;
  assign finish  = ((state_q == S_ACCESS) && all_fin && write_q) ||
                   (rd_hs && at_last);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (accept) state_d = S_ADDR;
      S_ADDR:   state_d = write_q ? S_GATHER : S_ACCESS;
      S_GATHER: if (wr_hs && at_last) state_d = S_ACCESS;
      S_ACCESS: if (all_fin) state_d = write_q ? S_IDLE : S_STREAM;
      S_STREAM: if (rd_hs && at_last) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      write_q <= 1'b0;
      row_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept) begin
        write_q <= req_write;
        row_q   <= req_addr;
        idx_q   <= '0;
      end else if (wr_hs || rd_hs) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // word buffer: filled from the bus on writes, from the banks on reads
  always_ff @(posedge clk) begin
    if (!rst_n)     buf_q <= '0;
    else if (fill)  buf_q <= bank_rdata;
    else if (wr_hs) buf_q[idx_q] <= wr_data;
  end

  // the last write word goes straight to its bank in the launch cycle
  for (genvar gi = 0; gi < NBANK; gi++) begin : g_wdata
    if (gi == NBANK - 1) begin : g_last
      assign bank_wdata[gi] = wr_data;
    end else begin : g_held
      assign bank_wdata[gi] = buf_q[gi];
    end
  end

  assign bank_start = ((state_q == S_ADDR) && !write_q) || (wr_hs && at_last);
  assign bank_we    = write_q;
  assign bank_row   = row_q;

  assign req_ready = (state_q == S_IDLE);
  assign wr_ready  = (state_q == S_GATHER);
  assign rd_valid  = (state_q == S_STREAM);
  assign rd_data   = buf_q[idx_q];
  assign done      = done_q;
endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl #(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 4,
  parameter int NBANK  = 4,
  parameter int LAT    = 15,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              done,
  output logic [CNT_W-1:0]  cyc_count
);
  logic                         bank_start;
  logic                         bank_we;
  logic [ROW_W-1:0]             bank_row;
  logic [NBANK-1:0][WORD_W-1:0] bank_wdata;
  logic [NBANK-1:0]             bank_fin;
  logic [NBANK-1:0][WORD_W-1:0] bank_rdata;

  ilv_seq #(
    .WORD_W(WORD_W), .ROW_W(ROW_W), .NBANK(NBANK)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .done       (done),
    .bank_start (bank_start),
    .bank_we    (bank_we),
    .bank_row   (bank_row),
    .bank_wdata (bank_wdata),
    .bank_fin   (bank_fin),
    .bank_rdata (bank_rdata)
  );

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    ilv_bank #(
      .WORD_W(WORD_W), .ROW_W(ROW_W), .LAT(LAT)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (bank_start),
      .we_i    (bank_we),
      .row_i   (bank_row),
      .wdata_i (bank_wdata[gb]),
      .fin_o   (bank_fin[gb]),
      .rdata_o (bank_rdata[gb])
    );
  end

  ilv_cyc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (req_valid && req_ready),
    .busy_i  (!req_ready),
    .count_o (cyc_count)
  );
endmodule

// File: rtl/ilv_refill_chk.sv
module ilv_refill_chk #(
  parameter int WORD_W = 32,
  parameter int LAT    = 15,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data,
  input logic              done,
  input logic [CNT_W-1:0]  cyc_count
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rd_valid && !wr_ready));

  p_first_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (cyc_count == CNT_W'(LAT + 1)));

  p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_count_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cyc_count == '0));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (cyc_count == CNT_W'($past(cyc_count) + 1'b1)));

  p_one_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready));
endmodule

bind ilv_refill_ctrl ilv_refill_chk #(
  .WORD_W(WORD_W), .LAT(LAT), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .done      (done),
  .cyc_count (cyc_count)
);

// File: tb/sim_ilv_refill_ctrl.sv
`timescale 1ns/1ps
module sim_ilv_refill_ctrl;
  localparam int ROW_W = 4;
  localparam int NBLK  = 1 << ROW_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic        done;
  logic [15:0] cyc_count;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  ilv_refill_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .cyc_count(cyc_count)
  );

  function automatic logic [31:0] expw(int blk, int w, int pass);
    return {8'hC3, 8'(pass), 8'(blk), 8'(w)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write one block; mode 1 leaves wr_valid low on odd cycles
  task automatic do_write(int blk, int pass, int mode);
    int t = 1, w = 0, stalls = 0;
    bit saw_rd = 0;
    @(negedge clk);
    chk(req_ready, "R2 idle ready", 32'(req_ready), 1);
    req_valid = 1; req_write = 1; req_addr = 4'(blk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R2 busy not ready", 32'(req_ready), 0);
    while (!done && t < 200) begin
      if (rd_valid) saw_rd = 1;
      if (wr_ready) begin
        wr_valid = (mode == 0) || (t % 2 == 0);
        wr_data  = expw(blk, w, pass);
        if (wr_valid) w++; else stalls++;
      end else begin
        wr_valid = 0;
      end
      @(negedge clk);
      t++;
    end
    wr_valid = 0;
    chk(!saw_rd, "R10 no read strobe on write", 32'(saw_rd), 0);
    chk(w == 4, "R6 four words taken", 32'(w), 4);
    chk(t == 21 + stalls, "R6 write done cycle", 32'(t), 32'(21 + stalls));
    chk(cyc_count == 16'(20 + stalls), "R9 write cycle count", 32'(cyc_count), 32'(20 + stalls));
    chk(req_ready, "R7 ready with done", 32'(req_ready), 1);
    @(negedge clk);
    chk(!done, "R7 done single pulse", 32'(done), 0);
  endtask

  // read one block; mode 1 stalls every third cycle; noise holds a write request high
  task automatic do_read(int blk, int pass, int mode, bit noise);
    int t = 1, w = 0, stalls = 0, first = 0;
    bit saw_wr = 0, prev_stall = 0, run_ok = 1, seen_end = 0;
    logic [31:0] prev_data = '0;
    @(negedge clk);
    chk(req_ready, "R2 idle ready", 32'(req_ready), 1);
    req_valid = 1; req_write = 0; req_addr = 4'(blk);
    @(negedge clk);
    if (noise) begin
      req_write = 1; req_addr = 4'(blk ^ 1);
    end else begin
      req_valid = 0;
    end
    while (!done && t < 200) begin
      if (wr_ready) saw_wr = 1;
      if (rd_valid) begin
        if (first == 0) first = t;
        if (seen_end) run_ok = 0;
        if (prev_stall)
          chk(rd_data == prev_data, "R5 word held under stall", rd_data, prev_data);
        rd_ready = (mode == 0) || (t % 3 != 0);
        if (rd_ready) begin
          chk(rd_data == expw(blk, w, pass), "R4 R8 word value and order", rd_data, expw(blk, w, pass));
          w++;
          prev_stall = 0;
        end else begin
          stalls++;
          prev_stall = 1;
        end
        prev_data = rd_data;
      end else begin
        if (first != 0) seen_end = 1;
        rd_ready = 0;
      end
      @(negedge clk);
      t++;
    end
    req_valid = 0;
    rd_ready  = 0;
    chk(!saw_wr, "R10 no write strobe on read", 32'(saw_wr), 0);
    chk(first == 17, "R3 first word cycle", 32'(first), 17);
    chk(run_ok, "R3 words back to back", 32'(run_ok), 1);
    chk(w == 4, "R4 four words", 32'(w), 4);
    chk(t == 21 + stalls, "R7 read done cycle", 32'(t), 32'(21 + stalls));
    chk(cyc_count == 16'(20 + stalls), "R9 read cycle count", 32'(cyc_count), 32'(20 + stalls));
    chk(req_ready, "R7 ready with done", 32'(req_ready), 1);
    @(negedge clk);
    chk(!done, "R7 done single pulse", 32'(done), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready && !rd_valid && !wr_ready && !done && cyc_count == 0,
        "R1 reset state", {req_ready, rd_valid, wr_ready, done, 12'(cyc_count)}, 32'h8000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rd_valid && !wr_ready && !done && cyc_count == 0,
        "R1 state after reset", {req_ready, rd_valid, wr_ready, done, 12'(cyc_count)}, 32'h8000);

    for (int b = 0; b < NBLK; b++) do_write(b, 0, 0);
    for (int b = 0; b < NBLK; b++) do_read(b, 0, 0, 0);
    for (int b = 0; b < NBLK; b++) do_write(b, 1, 1);
    for (int b = 0; b < NBLK; b++) do_read(b, 1, 1, 0);

    // R8: rewrite one block, all others keep their words
    do_write(5, 2, 0);
    for (int b = 0; b < NBLK; b++) do_read(b, (b == 5) ? 2 : 1, 0, 0);

    // R2: a request held high while busy is ignored; block 5^1 = 4 stays intact
    do_read(5, 2, 0, 1);
    repeat (3) @(negedge clk);
    chk(cyc_count == 16'd20, "R9 count holds in idle", 32'(cyc_count), 20);
    chk(req_ready && !rd_valid && !wr_ready, "R2 idle after ignored request",
        {req_ready, rd_valid, wr_ready}, 32'h4);
    do_read(4, 1, 0, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule